// File: doc/BRIEF.md
# Infrared SIR pulse codec

This block sits between a UART core and an infrared transceiver. It runs on the system clock and advances only on a one-cycle enable that marks each 16x baud tick. The top rate it is sized for is 115.2 kbit/s, which needs a 16x tick of about 1.843 MHz.

On the transmit side it takes the UART's serial bit. Each zero bit becomes a short high pulse at a fixed tick position inside that bit. A one bit gives no pulse.

On the receive side it takes the photodiode line. A polarity select can invert that line. The line then passes through a two-flop synchronizer. The decoder rebuilds a non-return-to-zero stream: every falling edge it sees becomes one full bit time of low output. Because only falling edges count, pulses of either polarity can be decoded. A positive pulse is decoded at its trailing edge unless the polarity select is set. The UART receiver that follows must sample at mid-bit, 8 ticks after the start edge. This keeps it clear of a possible one-tick high gap between back-to-back zeros.

Top module: `irda_sir_codec`

## Requirements
- R1: While `tx_bit` is 1, `ir_tx` is driven 0 on the next clock and the in-bit tick count is cleared, so the next zero bit starts counting from zero.
- R2: While `tx_bit` is 0, `ir_tx` rises at the 7th tick after the bit started and falls at the 10th tick, giving a pulse 3 ticks wide.
- R3: A bit period is 16 ticks. Consecutive zero bits each produce their own pulse, so the pulse starts are 16 ticks apart.
- R4: After reset, `ir_tx` is 0, `rx_bit` is 1 and the decoder's 4-bit tick count is cleared.
- R5: A falling edge on the synchronized receive line drives `rx_bit` low at the first tick after the edge is detected. `rx_bit` stays low for 16 ticks and then returns to 1. Two edges 17 ticks apart leave a one-tick high gap.
- R6: With no falling edge on the synchronized receive line, `rx_bit` stays 1. A rising edge alone has no effect.
- R7: With `rx_invert` = 1, the line is inverted before synchronization, so a positive pulse is decoded at its leading edge. With `rx_invert` = 0, a positive pulse is decoded at its trailing (falling) edge.
- R8: A new falling edge detected while `rx_bit` is already low restarts the 16-tick count. This holds even when it lands on the tick that would otherwise end the low period.
- R9: Apart from the clear in R1, `ir_tx` and `rx_bit` change only on clock edges where `tick16` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle enable at 16 times the bit rate |
| tx_bit | input | 1 | Serial bit from the UART transmitter, idle 1 |
| ir_tx | output | 1 | Drive to the infrared emitter, 1 = light pulse |
| ir_rx | input | 1 | Raw line from the infrared receiver |
| rx_invert | input | 1 | 1 = invert `ir_rx` before decoding |
| rx_bit | output | 1 | Rebuilt serial bit for the UART receiver |

## Verification
Two decoder functions can act on the same tick: the end of a 16-tick low period and the restart caused by a new falling edge. The bench provokes this by placing a second edge so that its detection lands exactly on the tick where the first low period would expire. The scoreboard then expects no rising event at that tick, only one 32-tick low span. A neighbouring case places the edge one tick later, and the scoreboard expects the one-tick high gap. This separates the two outcomes so that a wrong priority between restart and expiry is visible at the port.

// File: rtl/irda_sir_pkg.sv
package irda_sir_pkg;

  // True when an in-bit tick position lies inside the emitted pulse window.
  function automatic logic in_pulse(input int unsigned pos,
                                    input int unsigned first,
                                    input int unsigned stop);
    return (pos >= first) && (pos < stop);
  endfunction

  // Next value of a wrapping tick counter of the given modulus.
  function automatic int unsigned wrap_next(input int unsigned cur,
                                            input int unsigned modulus);
    return (cur + 1 >= modulus) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/sir_sync.sv
module sir_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sir_encoder.sv
module sir_encoder
  import irda_sir_pkg::*;
#(
  parameter int unsigned TICKS       = 16,
  parameter int unsigned PULSE_START = 7,
  parameter int unsigned PULSE_END   = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick16,
  input  logic tx_bit,
  output logic ir_tx
);
  localparam int unsigned CW = $clog2(TICKS);

  logic [CW-1:0] enc_cnt;
  logic [CW-1:0] cnt_next;

  always_comb cnt_next = CW'(wrap_next(32'(enc_cnt), TICKS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enc_cnt <= '0;
      ir_tx   <= 1'b0;
    end else if (tx_bit) begin
      enc_cnt <= '0;
      ir_tx   <= 1'b0;
    end else if (tick16) begin
      enc_cnt <= cnt_next;
      ir_tx   <= in_pulse(32'(cnt_next), PULSE_START, PULSE_END);
    end
  end

  assert_one_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_bit |=> (!ir_tx && enc_cnt == '0));

  assert_rise_position_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ir_tx) |-> (enc_cnt == CW'(PULSE_START)));

  assert_fall_position_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ir_tx) && !$past(tx_bit)) |-> (enc_cnt == CW'(PULSE_END)));

  assert_tx_tick_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick16 && !tx_bit) |=> $stable(ir_tx));
endmodule

// File: rtl/sir_decoder.sv
module sir_decoder #(
  parameter int unsigned TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick16,
  input  logic rx_line,
  output logic rx_bit
);
  localparam int unsigned CW = $clog2(TICKS);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic          line_d;
  logic          pend;
  logic          fall_now;
  logic          restart;
  logic [CW-1:0] dcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_d <= 1'b1;
    else        line_d <= rx_line;
  end

  assign fall_now = line_d & ~rx_line;
  assign restart  = pend | fall_now;

  // Hold a detected edge until the next tick consumes it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend <= 1'b0;
    else if (tick16)   pend <= 1'b0;
    else if (fall_now) pend <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_bit <= 1'b1;
      dcnt   <= '0;
    end else if (tick16) begin
      if (restart) begin
        rx_bit <= 1'b0;
        dcnt   <= '0;
      end else if (!rx_bit) begin
        if (dcnt == LAST) begin
          rx_bit <= 1'b1;
          dcnt   <= '0;
        end else begin
          dcnt <= dcnt + 1'b1;
        end
      end
    end
  end

  assert_high_count_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_bit |-> (dcnt == '0));

  assert_full_bit_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_bit) |-> ($past(dcnt) == LAST));

  assert_low_needs_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_bit) |-> $past(restart));

  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick16 && restart) |=> (!rx_bit && dcnt == '0));

  assert_rx_tick_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick16 |=> $stable(rx_bit));
endmodule

// File: rtl/irda_sir_codec.sv
module irda_sir_codec #(
  parameter int unsigned TICKS       = 16,
  parameter int unsigned PULSE_START = 7,
  parameter int unsigned PULSE_END   = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick16,
  input  logic tx_bit,
  output logic ir_tx,
  input  logic ir_rx,
  input  logic rx_invert,
  output logic rx_bit
);
  logic rx_pol;
  logic rx_sync;

  assign rx_pol = ir_rx ^ rx_invert;

  sir_encoder #(
    .TICKS(TICKS), .PULSE_START(PULSE_START), .PULSE_END(PULSE_END)
  ) u_enc (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .tx_bit(tx_bit), .ir_tx(ir_tx)
  );

  sir_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_pol), .q(rx_sync)
  );

  sir_decoder #(.TICKS(TICKS)) u_dec (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_line(rx_sync), .rx_bit(rx_bit)
  );
endmodule

// File: tb/sim_irda_sir_codec.sv
`timescale 1ns/1ps
module sim_irda_sir_codec;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick16 = 1'b0;
  logic tx_bit = 1'b1;
  logic ir_rx = 1'b1;
  logic rx_invert = 1'b0;
  logic ir_tx;
  logic rx_bit;

  int total = 0;
  int bad = 0;
  int tick_no = 0;
  int ph = 0;
  bit done = 0;
  int enc_q[$];
  int dec_q[$];
  logic last_tx;
  logic last_rx;

  always #5 clk = ~clk;

  irda_sir_codec u0 (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .tx_bit(tx_bit), .ir_tx(ir_tx),
    .ir_rx(ir_rx), .rx_invert(rx_invert), .rx_bit(rx_bit)
  );

  // Tick every fourth clock, numbered as it is raised.
  always @(negedge clk) begin
    if (rst_n) begin
      tick16 <= (ph == 3);
      if (ph == 3) tick_no <= tick_no + 1;
      ph <= (ph + 1) % 4;
    end
  end

  task automatic check(input bit ok, input string req, input int got, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  // Compare an observed edge (tick*2+level) with the scoreboard head.
  task automatic take(input bit enc, input int got, input string req);
    int exp;
    if (enc) begin
      if (enc_q.size() == 0) exp = -1; else exp = enc_q.pop_front();
    end else begin
      if (dec_q.size() == 0) exp = -1; else exp = dec_q.pop_front();
    end
    check(got == exp, req, got, exp);
  endtask

  task automatic after_tick();
    @(posedge clk iff tick16);
    @(negedge clk);
  endtask

  task automatic wait_until(input int t);
    while (tick_no < t) after_tick();
  endtask

  // Monitor: every output edge is popped against the expected item.
  initial begin
    wait (rst_n);
    last_tx = ir_tx;
    last_rx = rx_bit;
    forever begin
      @(posedge clk);
      #1;
      if (ir_tx !== last_tx) begin
        take(1'b1, tick_no * 2 + int'(ir_tx), "R1/R2/R3 encoder edge");
        last_tx = ir_tx;
      end
      if (rx_bit !== last_rx) begin
        take(1'b0, tick_no * 2 + int'(rx_bit), "R5/R6/R7/R8 decoder edge");
        last_rx = rx_bit;
      end
    end
  end

  initial begin
    int n;
    #23;
    check(ir_tx == 1'b0, "R4 ir_tx in reset", int'(ir_tx), 0);
    check(rx_bit == 1'b1, "R4 rx_bit in reset", int'(rx_bit), 1);
    @(negedge clk);
    rst_n = 1'b1;
    after_tick();

    // R3: three zero bits, one pulse each, 16 ticks apart (R2 window 7..10).
    n = tick_no;
    for (int j = 0; j < 3; j++) begin
      enc_q.push_back((n + 7 + 16 * j) * 2 + 1);
      enc_q.push_back((n + 10 + 16 * j) * 2);
    end
    tx_bit = 1'b0;
    wait_until(n + 48);
    tx_bit = 1'b1;
    wait_until(n + 64);

    // R1: a one cut in mid-pulse clears at once, then counting restarts at zero.
    n = tick_no;
    enc_q.push_back((n + 7) * 2 + 1);
    enc_q.push_back((n + 8) * 2);
    tx_bit = 1'b0;
    wait_until(n + 8);
    tx_bit = 1'b1;
    wait_until(n + 12);
    n = tick_no;
    enc_q.push_back((n + 7) * 2 + 1);
    enc_q.push_back((n + 10) * 2);
    tx_bit = 1'b0;
    wait_until(n + 16);
    tx_bit = 1'b1;
    wait_until(n + 20);
    check(enc_q.size() == 0, "R2 encoder pulses all seen", enc_q.size(), 0);

    // R6: idle line, output stays high.
    wait_until(tick_no + 30);
    check(rx_bit == 1'b1, "R6 idle stays high", int'(rx_bit), 1);

    // R5: single negative pulse.
    n = tick_no;
    dec_q.push_back((n + 1) * 2);
    dec_q.push_back((n + 17) * 2 + 1);
    ir_rx = 1'b0;
    wait_until(n + 3);
    ir_rx = 1'b1;
    wait_until(n + 8);
    check(rx_bit == 1'b0, "R5 low during bit", int'(rx_bit), 0);
    wait_until(n + 25);

    // R8: second edge 10 ticks in restarts the count.
    n = tick_no;
    dec_q.push_back((n + 1) * 2);
    dec_q.push_back((n + 27) * 2 + 1);
    ir_rx = 1'b0;
    wait_until(n + 3);
    ir_rx = 1'b1;
    wait_until(n + 10);
    ir_rx = 1'b0;
    wait_until(n + 13);
    ir_rx = 1'b1;
    wait_until(n + 35);

    // R8: restart lands on the expiry tick, no high tick at all.
    n = tick_no;
    dec_q.push_back((n + 1) * 2);
    dec_q.push_back((n + 33) * 2 + 1);
    ir_rx = 1'b0;
    wait_until(n + 3);
    ir_rx = 1'b1;
    wait_until(n + 16);
    ir_rx = 1'b0;
    wait_until(n + 19);
    ir_rx = 1'b1;
    wait_until(n + 40);

    // R5: edge one tick later, one-tick high gap.
    n = tick_no;
    dec_q.push_back((n + 1) * 2);
    dec_q.push_back((n + 17) * 2 + 1);
    dec_q.push_back((n + 18) * 2);
    dec_q.push_back((n + 34) * 2 + 1);
    ir_rx = 1'b0;
    wait_until(n + 3);
    ir_rx = 1'b1;
    wait_until(n + 17);
    ir_rx = 1'b0;
    wait_until(n + 20);
    ir_rx = 1'b1;
    wait_until(n + 40);

    // R7: inverted input, positive pulse decoded at leading edge.
    rx_invert = 1'b1;
    ir_rx = 1'b0;
    wait_until(tick_no + 4);
    n = tick_no;
    dec_q.push_back((n + 1) * 2);
    dec_q.push_back((n + 17) * 2 + 1);
    ir_rx = 1'b1;
    wait_until(n + 3);
    ir_rx = 1'b0;
    wait_until(n + 22);

    // R7: dropping the inversion with the pin low is itself a falling edge.
    n = tick_no;
    dec_q.push_back((n + 1) * 2);
    dec_q.push_back((n + 17) * 2 + 1);
    rx_invert = 1'b0;
    wait_until(n + 22);

    // R7/R6: non-inverted positive pulse, rise ignored, fall decoded.
    n = tick_no;
    dec_q.push_back((n + 4) * 2);
    dec_q.push_back((n + 20) * 2 + 1);
    ir_rx = 1'b1;
    wait_until(n + 3);
    check(rx_bit == 1'b1, "R6 rising edge ignored", int'(rx_bit), 1);
    ir_rx = 1'b0;
    wait_until(n + 26);

    check(dec_q.size() == 0, "R5 decoder edges all seen", dec_q.size(), 0);
    check(enc_q.size() == 0, "R9 no stray encoder edge", enc_q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog got=hang exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule